// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a parallel NOR-style flash interface and turns bus write cycles into memory operations. Every command is guarded by a fixed two-write unlock prefix. The command byte arrives on the third write. The block can enter an identification mode, program a single word, or erase the whole array. A small behavioural cell array sits behind the decoder.

Program and erase run as simulated embedded operations. For a configurable number of clock cycles an active-low ready/busy output is driven low, and any bus write is discarded. Read data is combinational from the current address. It comes from the cell array in normal mode, or from the identification and sector-protection values in identification mode. The synchronous hardware reset aborts any running operation without committing it. The array contents are kept through reset.

Unlock writes are data AAh at address 555h, then data 55h at address 2AAh. Commands sit in the low data byte and are written to address 555h: 90h identification, A0h program, 80h erase setup, 10h chip erase. The reset command is F0h, written to any address.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A program or erase takes effect only after the exact prefix AAh@555h, 55h@2AAh (address bits [11:0], data bits [7:0]), with the command on the third write at 555h; writes lacking that prefix leave the array and busy_n unchanged.
- R2: Any write that does not match the next expected step of a sequence returns the decoder to normal array reads, with no operation started.
- R3: After the 90h command the block stays in identification mode across any number of reads and any writes other than F0h.
- R4: In identification mode, offset addr[2:0]=0 returns 0001h; the device code (parameter DEV_CODE) is at offset 1 when byte_mode=0 and offset 2 when byte_mode=1; all other offsets that are not a protection offset return 0000h.
- R5: In identification mode, offset 2 (byte_mode=0) or offset 4 (byte_mode=1) returns 0001h if the sector addr[5:4] has its bit set in PROT_MASK, else 0000h.
- R6: A write with data F0h leaves identification mode, and reads return array data again.
- R7: Program is unlock, unlock, A0h@555h, then address/data. The addressed word (addr[5:0]) becomes old AND new, so a bit can go from 1 to 0 and never from 0 to 1.
- R8: busy_n goes low on the clock edge that accepts the final command write. It stays low for exactly BUSY_CYCLES cycles. The new array contents are readable on the edge where busy_n returns high.
- R9: Writes received while busy_n is low are discarded and do not affect the decoder state or the array.
- R10: Chip erase is unlock, unlock, 80h@555h, unlock, unlock, 10h@555h. It sets every array word to all ones.
- R11: rst_n low forces busy_n high on the next edge, aborts any running operation without changing the array, and returns the block to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle it is high |
| addr | input | ADDR_W | Bus address for writes and reads |
| wdata | input | DATA_W | Bus write data; commands in bits [7:0] |
| byte_mode | input | 1 | Selects byte-mode identification offsets |
| rdata | output | DATA_W | Combinational read data for addr |
| busy_n | output | 1 | Ready/busy, low while an embedded operation runs |

## Verification
The bench builds the block with a 64-word array in four sectors, PROT_MASK 0101b and BUSY_CYCLES of 4. The array is small enough that every word can be programmed twice with two computed patterns and checked against their AND, and checked again after each erase. The short busy window lets the bench count busy_n cycle by cycle and land writes inside it. Identification mode is swept over all four sectors, all eight offsets and both byte_mode settings, and each expected value is computed from the offset rules.

// File: rtl/flash_cmd_pkg.sv
// Shared types and bus constants for the flash command decoder.
// Assumes commands are carried in the low data byte and unlock
// addresses are compared on address bits [11:0].
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_AUTOSEL,
        S_PROG_ADDR,
        S_ERS_SETUP,
        S_ERS_UNL1,
        S_ERS_UNL2,
        S_BUSY
    } seq_state_t;

    typedef enum logic {
        OP_PROG,
        OP_ERASE
    } op_kind_t;

    localparam logic [11:0] UNLOCK_ADDR_A  = 12'h555;
    localparam logic [11:0] UNLOCK_ADDR_B  = 12'h2AA;
    localparam logic [7:0]  UNLOCK_DATA_A  = 8'hAA;
    localparam logic [7:0]  UNLOCK_DATA_B  = 8'h55;
    localparam logic [7:0]  CMD_AUTOSEL    = 8'h90;
    localparam logic [7:0]  CMD_PROG       = 8'hA0;
    localparam logic [7:0]  CMD_ERS_SETUP  = 8'h80;
    localparam logic [7:0]  CMD_CHIP_ERASE = 8'h10;
    localparam logic [7:0]  CMD_RESET      = 8'hF0;
    localparam logic [15:0] MFR_CODE       = 16'h0001;

endpackage

// File: rtl/flash_op_timer.sv
// Busy timer for embedded operations.
// Loads BUSY_CYCLES on start and counts down to zero. done is high
// in the last busy cycle. Assumes start never arrives while busy.
module flash_op_timer #(
    parameter int BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Count the remaining busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(BUSY_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r8_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !busy);

endmodule

// File: rtl/flash_cell_array.sv
// Behavioural cell array, one register word per address.
// Program ANDs the new data into the word; erase sets every word to
// ones. Contents survive reset, and nothing commits while rst_n is low.
module flash_cell_array #(
    parameter int AW     = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [AW-1:0]     prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        // Update one word on an erase or on a program aimed at it.
        always_ff @(posedge clk) begin
            if (rst_n) begin
                if (erase_en) begin
                    mem[w] <= '1;
                end else if (prog_en && prog_addr == AW'(w)) begin
                    mem[w] <= mem[w] & prog_data;
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

    a_r7_no_bit_rise: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ((mem[$past(prog_addr)] & ~$past(prog_data)) == '0));
    a_r10_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (mem[0] == '1 && mem[DEPTH-1] == '1));

endmodule

// File: rtl/flash_seq_fsm.sv
// Command sequence decoder.
// Tracks unlock prefixes and commands, latches the program target,
// and holds a busy state until the timer reports done. Assumes
// ADDR_W >= 12 so that the unlock addresses can be compared.
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int ARR_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              op_done,
    output logic              op_start,
    output logic              in_autosel,
    output logic              commit_prog,
    output logic              commit_erase,
    output logic [ARR_AW-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    seq_state_t state, state_nx;
    op_kind_t   op_kind;

    logic hit_a, hit_b, at_cmd_addr, is_reset;
    logic [7:0] cmd;

    assign cmd         = wdata[7:0];
    assign at_cmd_addr = (addr[11:0] == UNLOCK_ADDR_A);
    assign hit_a       = at_cmd_addr && (cmd == UNLOCK_DATA_A);
    assign hit_b       = (addr[11:0] == UNLOCK_ADDR_B) && (cmd == UNLOCK_DATA_B);
    assign is_reset    = (cmd == CMD_RESET);

    // Choose the next decoder state from the current write.
    always_comb begin
        state_nx = state;
        case (state)
            S_READ:      if (wr_en && hit_a) state_nx = S_UNL1;
            S_UNL1:      if (wr_en) state_nx = hit_b ? S_UNL2 : S_READ;
            S_UNL2: begin
                if (wr_en) begin
                    if (at_cmd_addr && cmd == CMD_AUTOSEL)        state_nx = S_AUTOSEL;
                    else if (at_cmd_addr && cmd == CMD_PROG)      state_nx = S_PROG_ADDR;
                    else if (at_cmd_addr && cmd == CMD_ERS_SETUP) state_nx = S_ERS_SETUP;
                    else                                          state_nx = S_READ;
                end
            end
            S_AUTOSEL:   if (wr_en && is_reset) state_nx = S_READ;
            S_PROG_ADDR: if (wr_en) state_nx = S_BUSY;
            S_ERS_SETUP: if (wr_en) state_nx = hit_a ? S_ERS_UNL1 : S_READ;
            S_ERS_UNL1:  if (wr_en) state_nx = hit_b ? S_ERS_UNL2 : S_READ;
            S_ERS_UNL2: begin
                if (wr_en) begin
                    state_nx = (at_cmd_addr && cmd == CMD_CHIP_ERASE) ? S_BUSY : S_READ;
                end
            end
            S_BUSY:      if (op_done) state_nx = S_READ;
            default:     state_nx = S_READ;
        endcase
    end

    assign op_start = wr_en && ((state == S_PROG_ADDR) ||
                      (state == S_ERS_UNL2 && at_cmd_addr && cmd == CMD_CHIP_ERASE));

    // Hold the decoder state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_READ;
        else        state <= state_nx;
    end

    // Latch the kind and target of an embedded operation as it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_kind <= OP_PROG;
            op_addr <= '0;
            op_data <= '1;
        end else if (op_start) begin
            op_kind <= (state == S_PROG_ADDR) ? OP_PROG : OP_ERASE;
            op_addr <= addr[ARR_AW-1:0];
            op_data <= wdata;
        end
    end

    assign in_autosel   = (state == S_AUTOSEL);
    assign commit_prog  = (state == S_BUSY) && op_done && (op_kind == OP_PROG);
    assign commit_erase = (state == S_BUSY) && op_done && (op_kind == OP_ERASE);

    a_r2_break_to_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_UNL1 && wr_en && !hit_b) |=> (state == S_READ));
    a_r3_autosel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AUTOSEL && !(wr_en && is_reset)) |=> (state == S_AUTOSEL));
    a_r6_reset_cmd_exits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AUTOSEL && wr_en && is_reset) |=> (state == S_READ));
    a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY && !op_done) |=>
        (state == S_BUSY && $stable(op_addr) && $stable(op_data)));

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command interface top level.
// Connects the sequence decoder, the busy timer and the cell array,
// and selects read data from the array or from the identification
// values. Assumes sector bits addr[ARR_AW-1 -: SECT_W] lie above
// the identification offset bits addr[2:0].
module flash_cmd_ctrl #(
    parameter int ADDR_W      = 12,
    parameter int DATA_W      = 16,
    parameter int ARR_AW      = 6,
    parameter int SECT_W      = 2,
    parameter int BUSY_CYCLES = 20,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h2258,
    parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] rdata,
    output logic              busy_n
);
    import flash_cmd_pkg::*;

    localparam int OFF_W = 3;

    logic              op_start, op_done, busy;
    logic              in_autosel, commit_prog, commit_erase;
    logic [ARR_AW-1:0] op_addr;
    logic [DATA_W-1:0] op_data, arr_rd, id_word;
    logic [SECT_W-1:0] sect;
    logic [OFF_W-1:0]  off;

    flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(ARR_AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .op_done(op_done), .op_start(op_start), .in_autosel(in_autosel),
        .commit_prog(commit_prog), .commit_erase(commit_erase),
        .op_addr(op_addr), .op_data(op_data)
    );

    flash_op_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(op_start), .busy(busy), .done(op_done)
    );

    flash_cell_array #(.AW(ARR_AW), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .prog_en(commit_prog), .prog_addr(op_addr),
        .prog_data(op_data), .erase_en(commit_erase),
        .rd_addr(addr[ARR_AW-1:0]), .rd_data(arr_rd)
    );

    assign sect = addr[ARR_AW-1 -: SECT_W];
    assign off  = addr[OFF_W-1:0];

    // Decode the identification word for the current offset.
    always_comb begin
        id_word = '0;
        if (off == OFF_W'(0)) begin
            id_word = DATA_W'(MFR_CODE);
        end else if (off == (byte_mode ? OFF_W'(2) : OFF_W'(1))) begin
            id_word = DEV_CODE;
        end else if (off == (byte_mode ? OFF_W'(4) : OFF_W'(2))) begin
            id_word = DATA_W'(PROT_MASK[sect]);
        end
    end

    assign rdata  = in_autosel ? id_word : arr_rd;
    assign busy_n = !busy;

    a_r11_hw_reset_ready: assert property (@(posedge clk)
        !rst_n |=> busy_n);
    a_r9_no_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !op_start);

endmodule

// File: tb/flash_cmd_ctrl_test.sv
// Self-checking bench for flash_cmd_ctrl with a 64-word array.
module flash_cmd_ctrl_test;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 16;
    localparam int AW     = 6;
    localparam int WORDS  = 1 << AW;
    localparam int BUSY   = 4;
    localparam logic [15:0] DEV  = 16'h22D6;
    localparam logic [3:0]  PROT = 4'b0101;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              byte_mode = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic              busy_n;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [WORDS];

    flash_cmd_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARR_AW(AW), .SECT_W(2),
        .BUSY_CYCLES(BUSY), .DEV_CODE(DEV), .PROT_MASK(PROT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .byte_mode(byte_mode), .rdata(rdata), .busy_n(busy_n)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
        addr = a;
        #1;
        chk(tag, rdata, exp);
        @(negedge clk);
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    task automatic wait_ready(input bit timed);
        if (timed) chk("R8 busy at accept", {15'd0, busy_n}, 16'd0);
        for (int i = 1; i < BUSY; i++) begin
            @(negedge clk);
            if (timed) chk("R8 busy window", {15'd0, busy_n}, 16'd0);
        end
        @(negedge clk);
        chk("R8 ready after window", {15'd0, busy_n}, 16'd1);
    endtask

    task automatic prog(input logic [5:0] a, input logic [15:0] d, input bit timed);
        unlock();
        wr(12'h555, 16'h00A0);
        wr({6'h2A, a}, d);
        wait_ready(timed);
        model[a] = model[a] & d;
    endtask

    task automatic erase_all();
        unlock();
        wr(12'h555, 16'h0080);
        unlock();
        wr(12'h555, 16'h0010);
        wait_ready(1'b1);
        for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < WORDS; i++) rd(12'(i), model[i], tag);
    endtask

    task automatic summary();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset state busy_n", {15'd0, busy_n}, 16'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 erase, then full sweep of ones
        erase_all();
        sweep("R10 erase sweep");

        // R7 two program passes with computed patterns, AND result
        for (int i = 0; i < WORDS; i++)
            prog(6'(i), 16'(i * 16'h0123) ^ 16'hA5C3, i < 2);
        sweep("R7 program pass 1");
        for (int i = 0; i < WORDS; i++)
            prog(6'(i), ~(16'(i * 16'h0101)) ^ 16'h0F0F, 1'b0);
        sweep("R7 program pass 2 AND");

        // R7 setting bits back to one has no effect
        prog(6'd5, 16'hFFFF, 1'b0);
        rd(12'd5, model[5], "R7 no 0-to-1");

        // R1 wrong first unlock address: no program, no busy
        wr(12'h554, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        wr(12'h555, 16'h00A0);
        wr(12'h003, 16'h0000);
        chk("R1 no busy without prefix", {15'd0, busy_n}, 16'd1);
        rd(12'd3, model[3], "R1 word unchanged");

        // R2 broken second unlock, then 90h: still array reads
        wr(12'h555, 16'h00AA);
        wr(12'h2AB, 16'h0055);
        wr(12'h555, 16'h0090);
        rd(12'd0, model[0], "R2 broken unlock");
        // R2 unknown command after prefix
        unlock();
        wr(12'h555, 16'h0033);
        wr(12'h009, 16'h0000);
        rd(12'd9, model[9], "R2 unknown command");
        // R2 broken erase: wrong final command
        unlock();
        wr(12'h555, 16'h0080);
        unlock();
        wr(12'h555, 16'h0030);
        chk("R2 broken erase no busy", {15'd0, busy_n}, 16'd1);
        rd(12'd1, model[1], "R2 broken erase array");

        // R3 R4 R5 identification sweep
        unlock();
        wr(12'h555, 16'h0090);
        for (int bm = 0; bm < 2; bm++) begin
            byte_mode = 1'(bm);
            for (int s = 0; s < 4; s++) begin
                for (int o = 0; o < 8; o++) begin
                    logic [15:0] e;
                    e = 16'h0000;
                    if (o == 0) e = 16'h0001;
                    else if (o == (bm ? 2 : 1)) e = DEV;
                    else if (o == (bm ? 4 : 2)) e = {15'd0, PROT[s]};
                    rd(12'h300 | 12'(s << 4) | 12'(o), e,
                       (o == (bm ? 4 : 2)) ? "R5 protect" : "R4 id code");
                end
            end
        end
        byte_mode = 1'b0;
        // R3 non-reset writes keep identification mode
        wr(12'h555, 16'h00AA);
        wr(12'h123, 16'h0000);
        rd(12'h001, DEV, "R3 stays in id mode");
        rd(12'h000, 16'h0001, "R3 repeat read");
        // R6 reset command
        wr(12'h7FF, 16'h00F0);
        rd(12'h001, model[1], "R6 back to array");
        rd(12'h000, model[0], "R6 back to array");

        // R10 second erase
        erase_all();
        sweep("R10 erase after program");

        // R9 writes during busy are discarded
        unlock();
        wr(12'h555, 16'h00A0);
        wr(12'h007, 16'h1234);
        chk("R9 busy started", {15'd0, busy_n}, 16'd0);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        chk("R9 still busy", {15'd0, busy_n}, 16'd0);
        @(negedge clk);
        @(negedge clk);
        chk("R9 ready on time", {15'd0, busy_n}, 16'd1);
        model[7] = 16'h1234;
        wr(12'h555, 16'h0090);
        rd(12'h000, model[0], "R9 unlock in busy ignored");
        rd(12'h007, 16'h1234, "R9 program committed");

        // R11 hardware reset aborts a program
        unlock();
        wr(12'h555, 16'h00A0);
        wr(12'h00C, 16'h0000);
        chk("R11 busy before reset", {15'd0, busy_n}, 16'd0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 ready after reset", {15'd0, busy_n}, 16'd1);
        repeat (BUSY) @(negedge clk);
        chk("R11 stays ready", {15'd0, busy_n}, 16'd1);
        rd(12'h00C, model[12], "R11 aborted word unchanged");
        prog(6'd12, 16'h00FF, 1'b1);
        rd(12'h00C, 16'h00FF, "R11 program after reset");

        summary();
    end

endmodule